// File: doc/BRIEF.md
# DMA Transfer Timing Sequencer

This block is a four-channel DMA service sequencer. Each channel keeps a current address, a current word count and a transfer type, and can be masked. When an unmasked channel requests service, the sequencer raises a bus hold request to the host. Once the host acknowledges, it walks through named one-clock working states that drive the address, the upper-address strobe and enable, the channel acknowledge, and the active-low memory and I/O strobes. One transfer is made per grant, and then the bus is handed back.

Three transfer types are supported. In I/O-to-memory and memory-to-I/O transfers the peripheral and memory strobes overlap, so data moves directly between them and never through the block. In memory-to-memory transfers the block runs a read half and then a write half. The byte is held in an internal register between the two halves, and the destination comes from a separate destination address register. A low READY input stretches a transfer with wait states. The host programs the block through a simple write port. That port works only while the bus is still the host's.

Top module: `dma_seq`

## Requirements
- R1: After reset, hrq_o, aen_o, adstb_o and data_oe_o are low, all four bus strobes are high, dack_o is 4'b1111 (acknowledge active low), and every channel is masked.
- R2: A request on dreq_i[n] whose mask bit n is clear raises hrq_o at the next clock edge. A request on a masked channel leaves hrq_o low. The mask is written with reg_addr_i = 4'b1100, where wdata bit n = 1 masks channel n.
- R3: The sequencer stays in the hold-wait state, with aen_o low, for as long as hlda_i is low. It enters the first working state at the first edge at which hlda_i is high.
- R4: The channel is chosen on leaving hold-wait by fixed priority, with channel 0 highest and channel 3 lowest. A higher-priority request that arrives during hold-wait wins.
- R5: In the first working state, adstb_o and aen_o are high and addr_o holds the transfer address. aen_o stays high through the last working state, and adstb_o lasts one cycle.
- R6: Mode 0 (I/O-to-memory) drives ior_no low in working states 2 to 4 and memw_no low in states 3 to 4. dack_o shows the active level on the granted channel in states 2 to 4. The mode is written with reg_addr_i = {2'b10, ch}, wdata[1:0].
- R7: Mode 1 (memory-to-I/O) drives memr_no low in states 2 to 4 and iow_no low in states 3 to 4.
- R8: If ready_i is low at the edge that ends state 3, wait states follow. Each wait state holds the strobes, and state 4 comes after the first edge that sees ready_i high.
- R9: After each transfer the channel address increments and the word count decrements. tc_o is high in the final state 4 when the count was 0, and the count then wraps to 16'hFFFF. The address is written with reg_addr_i = {2'b00, ch} and the count with {2'b01, ch}.
- R10: Mode 2 (memory-to-memory) runs eight working states. The read half puts the channel address on addr_o, drives memr_no low in states 2 to 4, and captures data_i at the end of its state 4. The write half puts the destination address on addr_o (written with reg_addr_i = 4'b1110), drives data_o with data_oe_o high in states 2 to 4, and drives memw_no low in states 3 to 4. No acknowledge is given in this mode.
- R11: After the last working state the sequencer returns to idle with hrq_o low for at least one cycle.
- R12: Register writes take effect in idle and in hold-wait. They are ignored in working states.
- R13: Writing 1 to wdata[0] at reg_addr_i = 4'b1101 makes dack_o active high. Writing 0 makes it active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register select {kind, channel} |
| reg_wdata_i | input | 16 | Register write data |
| dreq_i | input | 4 | Channel service requests, active high |
| hrq_o | output | 1 | Bus hold request to host |
| hlda_i | input | 1 | Hold acknowledge from host |
| ready_i | input | 1 | Low inserts wait states |
| data_i | input | 8 | Read data for memory-to-memory |
| addr_o | output | 16 | Transfer address |
| adstb_o | output | 1 | Upper address latch strobe |
| aen_o | output | 1 | Address enable onto the bus |
| dack_o | output | 4 | Channel acknowledges, programmable level |
| memr_no | output | 1 | Memory read strobe, active low |
| memw_no | output | 1 | Memory write strobe, active low |
| ior_no | output | 1 | I/O read strobe, active low |
| iow_no | output | 1 | I/O write strobe, active low |
| data_o | output | 8 | Write data for memory-to-memory |
| data_oe_o | output | 1 | data_o valid |
| tc_o | output | 1 | Terminal count flag |

## Verification
Two pairs of functions can coincide here. The first pair is a host register write and the sequencer leaving the window in which writes are accepted. The bench lands one write in hold-wait and another in working state 2, on the same channel's address. The first must appear on addr_o in the next state 1, and the second must leave the following transfer's address at its incremented value. The second pair is priority selection and a new request arriving while the sequencer is already in hold-wait. A lower channel raises the request, a higher one joins before hlda_i, and the acknowledge in state 2 must name the higher channel.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_S1, ST_S2, ST_S3, ST_SW, ST_S4
  } state_e;

  typedef enum logic [1:0] {
    XF_IO2MEM  = 2'd0,
    XF_MEM2IO  = 2'd1,
    XF_MEM2MEM = 2'd2,
    XF_RSVD    = 2'd3
  } xfer_e;
endpackage

// File: rtl/dma_prio.sv
module dma_prio #(
  parameter int N_CH = 4,
  localparam int CW = $clog2(N_CH)
) (
  input  logic [N_CH-1:0] req_i,
  output logic            valid_o,
  output logic [CW-1:0]   idx_o
);
  always_comb begin
    valid_o = |req_i;
    idx_o   = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = CW'(i);
    end
  end
endmodule

// File: rtl/dma_chan_file.sv
module dma_chan_file import dma_seq_pkg::*; #(
  parameter int N_CH = 4,
  parameter int AW   = 16,
  localparam int CW = $clog2(N_CH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    wsel_i,
  input  logic [CW-1:0] wch_i,
  input  logic [AW-1:0] wdata_i,
  input  logic [CW-1:0] sel_i,
  input  logic          adv_addr_i,
  input  logic          adv_cnt_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] cnt_o,
  output xfer_e         mode_o
);
  logic [AW-1:0] addr_q [N_CH];
  logic [AW-1:0] cnt_q  [N_CH];
  xfer_e         mode_q [N_CH];

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q[g] <= '0;
        cnt_q[g]  <= '0;
        mode_q[g] <= XF_IO2MEM;
      end else if (we_i && wch_i == CW'(g)) begin
        case (wsel_i)
          2'd0:    addr_q[g] <= wdata_i;
          2'd1:    cnt_q[g]  <= wdata_i;
          2'd2:    mode_q[g] <= xfer_e'(wdata_i[1:0]);
          default: ;
        endcase
      end else if (sel_i == CW'(g)) begin
        if (adv_addr_i) addr_q[g] <= addr_q[g] + 1'b1;
        if (adv_cnt_i)  cnt_q[g]  <= cnt_q[g] - 1'b1;
      end
    end
  end

  assign addr_o = addr_q[sel_i];
  assign cnt_o  = cnt_q[sel_i];
  assign mode_o = mode_q[sel_i];
endmodule

// File: rtl/dma_seq.sv
module dma_seq import dma_seq_pkg::*; #(
  parameter int N_CH = 4,
  parameter int AW   = 16,
  parameter int DW   = 8,
  localparam int CW  = $clog2(N_CH),
  localparam int RAW = CW + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [RAW-1:0]  reg_addr_i,
  input  logic [AW-1:0]   reg_wdata_i,
  input  logic [N_CH-1:0] dreq_i,
  output logic            hrq_o,
  input  logic            hlda_i,
  input  logic            ready_i,
  input  logic [DW-1:0]   data_i,
  output logic [AW-1:0]   addr_o,
  output logic            adstb_o,
  output logic            aen_o,
  output logic [N_CH-1:0] dack_o,
  output logic            memr_no,
  output logic            memw_no,
  output logic            ior_no,
  output logic            iow_no,
  output logic [DW-1:0]   data_o,
  output logic            data_oe_o,
  output logic            tc_o
);
  state_e          state_q, state_d;
  logic            half_q;
  logic [CW-1:0]   chan_q;
  logic [N_CH-1:0] mask_q;
  logic            dack_hi_q;
  logic [AW-1:0]   dest_q;
  logic [DW-1:0]   temp_q;

  logic [N_CH-1:0] pend;
  logic            pend_any;
  logic [CW-1:0]   win;
  logic [AW-1:0]   cur_addr, cur_cnt;
  xfer_e           cur_mode;
  logic            reg_ok, wr_en, at_s4, is_m2m, is_m2i;
  logic            rd_ph, wr_ph, adv_addr, adv_cnt;
  logic [1:0]      wsel;
  logic [CW-1:0]   wch;

  assign pend   = dreq_i & ~mask_q;
  assign reg_ok = (state_q == ST_IDLE) || (state_q == ST_HOLD);
  assign wr_en  = reg_we_i && reg_ok;
  assign wsel   = reg_addr_i[RAW-1 -: 2];
  assign wch    = reg_addr_i[CW-1:0];

  dma_prio #(.N_CH(N_CH)) u_prio (
    .req_i  (pend),
    .valid_o(pend_any),
    .idx_o  (win)
  );

  assign is_m2m   = (cur_mode == XF_MEM2MEM);
  assign is_m2i   = (cur_mode == XF_MEM2IO);
  assign at_s4    = (state_q == ST_S4);
  assign adv_addr = at_s4 && !(is_m2m && half_q);
  assign adv_cnt  = at_s4 && (!is_m2m || half_q);

  dma_chan_file #(.N_CH(N_CH), .AW(AW)) u_chans (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_en && wsel != 2'd3),
    .wsel_i    (wsel),
    .wch_i     (wch),
    .wdata_i   (reg_wdata_i),
    .sel_i     (chan_q),
    .adv_addr_i(adv_addr),
    .adv_cnt_i (adv_cnt),
    .addr_o    (cur_addr),
    .cnt_o     (cur_cnt),
    .mode_o    (cur_mode)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (pend_any) state_d = ST_HOLD;
      ST_HOLD: if (!pend_any) state_d = ST_IDLE;
               else if (hlda_i) state_d = ST_S1;
      ST_S1:   state_d = ST_S2;
      ST_S2:   state_d = ST_S3;
      ST_S3,
      ST_SW:   state_d = ready_i ? ST_S4 : ST_SW;
      ST_S4:   state_d = (is_m2m && !half_q) ? ST_S1 : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      half_q    <= 1'b0;
      chan_q    <= '0;
      mask_q    <= '1;
      dack_hi_q <= 1'b0;
      dest_q    <= '0;
      temp_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_HOLD && state_d == ST_S1) begin
        chan_q <= win;
        half_q <= 1'b0;
      end
      if (at_s4 && is_m2m && !half_q) begin
        temp_q <= data_i;
        half_q <= 1'b1;
      end
      if (at_s4 && is_m2m && half_q) dest_q <= dest_q + 1'b1;
      if (wr_en && wsel == 2'd3) begin
        case (wch)
          CW'(0):  mask_q    <= reg_wdata_i[N_CH-1:0];
          CW'(1):  dack_hi_q <= reg_wdata_i[0];
          CW'(2):  dest_q    <= reg_wdata_i;
          default: ;
        endcase
      end
    end
  end

  // Read strobe covers S2..S4, write strobe S3..S4 (waits included)
  assign rd_ph = (state_q == ST_S2) || (state_q == ST_S3) || (state_q == ST_SW) || at_s4;
  assign wr_ph = (state_q == ST_S3) || (state_q == ST_SW) || at_s4;

  always_comb begin
    memr_no = 1'b1;
    memw_no = 1'b1;
    ior_no  = 1'b1;
    iow_no  = 1'b1;
    if (is_m2m) begin
      if (!half_q) memr_no = !rd_ph;
      else         memw_no = !wr_ph;
    end else if (is_m2i) begin
      memr_no = !rd_ph;
      iow_no  = !wr_ph;
    end else begin
      ior_no  = !rd_ph;
      memw_no = !wr_ph;
    end
  end

  logic [N_CH-1:0] dack_act;
  always_comb begin
    dack_act = '0;
    if (rd_ph && !is_m2m) dack_act[chan_q] = 1'b1;
  end

  assign dack_o    = dack_hi_q ? dack_act : ~dack_act;
  assign hrq_o     = (state_q != ST_IDLE);
  assign aen_o     = !reg_ok;
  assign adstb_o   = (state_q == ST_S1);
  assign addr_o    = !aen_o ? '0 : ((is_m2m && half_q) ? dest_q : cur_addr);
  assign data_o    = temp_q;
  assign data_oe_o = is_m2m && half_q && rd_ph;
  assign tc_o      = adv_cnt && (cur_cnt == '0);
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic hrq_o,
  input logic hlda_i,
  input logic aen_o,
  input logic adstb_o,
  input logic memr_no,
  input logic memw_no,
  input logic ior_no,
  input logic iow_no,
  input logic tc_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aen_o |-> (memr_no && memw_no && ior_no && iow_no));

  assert_grant_needs_hlda_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aen_o) |-> ($past(hlda_i) && $past(hrq_o)));

  assert_aen_under_hrq_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aen_o |-> hrq_o);

  assert_adstb_in_aen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adstb_o |-> aen_o);

  assert_adstb_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adstb_o |=> !adstb_o);

  assert_ior_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ior_no |-> (iow_no && memr_no));

  assert_tc_in_xfer_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> (aen_o && !adstb_o));

  assert_mem_rw_apart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!memr_no && !memw_no));

  assert_bus_released_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(aen_o) |-> !hrq_o);
endmodule

bind dma_seq dma_seq_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .hrq_o  (hrq_o),
  .hlda_i (hlda_i),
  .aen_o  (aen_o),
  .adstb_o(adstb_o),
  .memr_no(memr_no),
  .memw_no(memw_no),
  .ior_no (ior_no),
  .iow_no (iow_no),
  .tc_o   (tc_o)
);

// File: tb/dma_seq_bench.sv
module dma_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [3:0]  dreq_i = '0;
  logic        hlda_i = 1'b0;
  logic        ready_i = 1'b1;
  logic [7:0]  data_i = '0;
  logic        hrq_o, adstb_o, aen_o, memr_no, memw_no, ior_no, iow_no, data_oe_o, tc_o;
  logic [15:0] addr_o;
  logic [3:0]  dack_o;
  logic [7:0]  data_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  dma_seq u_dma_seq (.*);

  task automatic step();
    @(posedge clk_i);
    #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    step();
    reg_we_i = 1'b0;
  endtask

  // raise requests, host answers one clock late; ends in state S1
  task automatic grant(input logic [3:0] req);
    dreq_i = req;
    step();
    chk("R2 hrq raised", hrq_o, 1);
    chk("R3 no aen before hlda", aen_o, 0);
    step();
    chk("R3 held in hold-wait", aen_o, 0);
    hlda_i = 1'b1;
    step();
  endtask

  task automatic release_bus();
    dreq_i = '0;
    step();
    chk("R11 hrq low after transfer", hrq_o, 0);
    chk("R11 aen low after transfer", aen_o, 0);
    hlda_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 hrq", hrq_o, 0);
    chk("R1 aen", aen_o, 0);
    chk("R1 adstb", adstb_o, 0);
    chk("R1 dack", dack_o, 4'hF);
    chk("R1 strobes", {memr_no, memw_no, ior_no, iow_no}, 4'hF);
    chk("R1 data_oe", data_oe_o, 0);
    dreq_i = 4'b0001;
    step(); step();
    chk("R1 masked after reset", hrq_o, 0);
    dreq_i = '0;
  endtask

  task automatic t_io2mem();
    wr(4'b0010, 16'h1234);
    wr(4'b0110, 16'h0000);
    wr(4'b1010, 16'h0000);
    wr(4'b1100, 16'h0000);
    grant(4'b0100);
    chk("R5 adstb in S1", adstb_o, 1);
    chk("R5 aen in S1", aen_o, 1);
    chk("R5 address", addr_o, 16'h1234);
    step();
    chk("R6 ior low S2", ior_no, 0);
    chk("R6 memw high S2", memw_no, 1);
    chk("R6 dack ch2", dack_o, 4'b1011);
    chk("R5 adstb one cycle", adstb_o, 0);
    step();
    chk("R6 overlap S3", {ior_no, memw_no}, 2'b00);
    step();
    chk("R6 overlap S4", {ior_no, memw_no}, 2'b00);
    chk("R9 tc at zero count", tc_o, 1);
    release_bus();
  endtask

  task automatic t_mem2io_wait();
    wr(4'b1010, 16'h0001);
    grant(4'b0100);
    chk("R9 address incremented", addr_o, 16'h1235);
    step();
    chk("R7 memr low S2", memr_no, 0);
    chk("R7 iow high S2", iow_no, 1);
    ready_i = 1'b0;
    step();
    chk("R7 overlap S3", {memr_no, iow_no}, 2'b00);
    step();
    chk("R8 wait holds strobes", {memr_no, iow_no}, 2'b00);
    chk("R8 no tc in wait", tc_o, 0);
    step();
    chk("R8 second wait", {memr_no, iow_no, aen_o}, 3'b001);
    chk("R8 still waiting", tc_o, 0);
    ready_i = 1'b1;
    step();
    chk("R8 S4 strobes", {memr_no, iow_no}, 2'b00);
    chk("R9 count wrapped, no tc", tc_o, 0);
    release_bus();
  endtask

  task automatic t_priority_mask();
    wr(4'b0001, 16'h0100);
    wr(4'b0101, 16'h0005);
    wr(4'b1001, 16'h0000);
    wr(4'b0011, 16'h0300);
    wr(4'b1011, 16'h0000);
    dreq_i = 4'b1000;
    step();
    chk("R4 hrq from ch3", hrq_o, 1);
    dreq_i = 4'b1010;
    step();
    hlda_i = 1'b1;
    step();
    chk("R4 late higher channel address", addr_o, 16'h0100);
    step();
    chk("R4 dack names ch1", dack_o, 4'b1101);
    step(); step();
    release_bus();
    wr(4'b1100, 16'h0008);
    dreq_i = 4'b1000;
    step(); step();
    chk("R2 masked request ignored", hrq_o, 0);
    dreq_i = '0;
    wr(4'b1100, 16'h0000);
  endtask

  task automatic t_reg_window();
    dreq_i = 4'b0010;
    step();
    wr(4'b0001, 16'h0200);
    hlda_i = 1'b1;
    step();
    chk("R12 write in hold-wait taken", addr_o, 16'h0200);
    step();
    wr(4'b0001, 16'h7777);
    step();
    release_bus();
    grant(4'b0010);
    chk("R12 write in S2 ignored", addr_o, 16'h0201);
    step(); step(); step();
    release_bus();
  endtask

  task automatic t_mem2mem();
    wr(4'b0000, 16'h0040);
    wr(4'b0100, 16'h0000);
    wr(4'b1000, 16'h0002);
    wr(4'b1110, 16'h0800);
    grant(4'b0001);
    chk("R10 source address", addr_o, 16'h0040);
    step();
    data_i = 8'hA5;
    chk("R10 memr low read S2", memr_no, 0);
    chk("R10 no dack", dack_o, 4'hF);
    step(); step();
    chk("R10 read S4 strobes", {memr_no, memw_no}, 2'b01);
    chk("R10 no tc in read half", tc_o, 0);
    step();
    data_i = 8'h00;
    chk("R10 write S1 dest", addr_o, 16'h0800);
    chk("R10 write S1 adstb", {adstb_o, hrq_o}, 2'b11);
    step();
    chk("R10 data held", data_o, 8'hA5);
    chk("R10 data_oe", data_oe_o, 1);
    chk("R10 memw high write S2", memw_no, 1);
    step();
    chk("R10 memw low write S3", {memr_no, memw_no}, 2'b10);
    step();
    chk("R9 tc in final half", tc_o, 1);
    release_bus();
    chk("R10 data_oe off", data_oe_o, 0);
  endtask

  task automatic t_polarity();
    wr(4'b1101, 16'h0001);
    chk("R13 idle dack active high", dack_o, 4'h0);
    wr(4'b1000, 16'h0000);
    grant(4'b0001);
    step();
    chk("R13 dack ch0 active high", dack_o, 4'b0001);
    step(); step();
    release_bus();
    wr(4'b1101, 16'h0000);
    chk("R13 back to active low", dack_o, 4'hF);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2;
    rst_ni = 1'b1;
    step();
    t_reset();
    t_io2mem();
    t_mem2io_wait();
    t_priority_mask();
    t_reg_window();
    t_mem2mem();
    t_polarity();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule